// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital sequencer for a small successive-approximation analog-to-digital converter with four multiplexed analog inputs. A one-cycle start strobe latches a channel number, drives the multiplexer select, and runs a fixed-length sample phase. A trial phase follows. In each trial step the block presents a trial code to an external DAC and comparator model. At the end of the step it reads back one comparator bit that says whether the input is at or above the trial level. The DAC, the comparator and the bus decoding all sit outside the block.

The block resolves a 5-bit code. It reports that code in two forms. The first is a raw byte with the code in the top five bits. The second is a 4-bit value that adds the lowest code bit as a round-up carry and clamps an overflow to full scale. A sticky done flag and a one-cycle interrupt pulse mark completion. All phase timing is counted in system-clock cycles.

The controller has three states. `ST_IDLE` waits for a start. `ST_SAMPLE` holds the sample window. `ST_TRIAL` walks the code bits from the top one down. The transitions are:
- start: `ST_IDLE` to `ST_SAMPLE`, taken on an accepted start.
- sample_done: `ST_SAMPLE` to `ST_TRIAL`, taken when the sample count runs out.
- next_bit: `ST_TRIAL` to `ST_TRIAL`, taken at the end of a step that is not the last.
- finish: `ST_TRIAL` to `ST_IDLE`, taken at the end of the step for bit 0.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, raw_byte_o, corr_o, done_o, irq_o, busy_o and sample_o are all 0, and trial_code_o is 0.
- R2: A start_i pulse seen in idle latches chan_i onto mux_sel_o. sample_o is then high for exactly 12 cycles, beginning the cycle after the start edge.
- R3: busy_o is high for exactly 160 cycles after an accepted start. done_o and irq_o rise on the same edge at which busy_o falls.
- R4: The trial phase tests bits from bit 4 down to bit 0. A tested bit is kept when comp_i is 1, meaning the input is at or above trial_code_o. The final code therefore equals the input level of the selected channel for any 5-bit level.
- R5: During the step for bit b, trial_code_o has bit b set, the bits below b clear, and the bits above b equal to the bits already kept. The five steps last 30, 30, 30, 29 and 29 cycles, in order from bit 4.
- R6: raw_byte_o holds the 5-bit result in bits [7:3], with bits [2:0] at 0.
- R7: corr_o equals result[4:1] plus result[0]. A sum of 16 is clamped to 15, so inputs 29, 30 and 31 all give 15.
- R8: A start_i pulse while busy_o is high is ignored. mux_sel_o keeps the latched channel, and the conversion ends at the same cycle it would have ended without the pulse.
- R9: irq_o is high for exactly one cycle per conversion. done_o stays high until the next accepted start, and drops on that start edge.
- R10: raw_byte_o and corr_o keep the previous result for the whole of a new conversion and change only on its completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle conversion start strobe |
| chan_i | input | 2 | Channel to convert, latched at start |
| comp_i | input | 1 | Comparator result: 1 when input is at or above trial level |
| mux_sel_o | output | 2 | Analog multiplexer select |
| sample_o | output | 1 | High during the sample window |
| trial_code_o | output | 5 | Trial level sent to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | One-cycle completion pulse |
| raw_byte_o | output | 8 | Raw 5-bit result in bits [7:3] |
| corr_o | output | 4 | Rounded, saturated 4-bit result |

## Verification
The bench uses input levels 29, 30 and 31 to test the clamp. A design that forgets the clamp would wrap the corrected value to 0 at 31, and a design that drops the round-up carry would report 14 at 29. A second start is injected in the middle of a conversion. A design that restarts on it would switch the multiplexer and stretch busy past 160 cycles. The bench measures the sample window and each step length against the uneven 30/30/30/29/29 split. An off-by-one counter shows up there as a 161-cycle or 159-cycle conversion. The bench also checks that the raw and corrected outputs keep the old result during the next conversion.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_TRIAL  = 2'd2
    } seq_state_t;

    // Length in cycles of trial step k (k = 0 tests the top bit); the trial
    // budget is split evenly with the leftover cycles given to the first steps.
    function automatic int step_cycles(input int k, input int res,
                                       input int sample, input int total);
        int base;
        int rem;
        base = (total - sample) / res;
        rem  = (total - sample) % res;
        return base + ((k < rem) ? 1 : 0);
    endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS   = 5,
    parameter int SAMPLE_CYC = 12,
    parameter int TOTAL_CYC  = 160,
    localparam int BASE_CYC  = (TOTAL_CYC - SAMPLE_CYC) / RES_BITS,
    localparam int LONG_CYC  = BASE_CYC + (((TOTAL_CYC - SAMPLE_CYC) % RES_BITS) > 0 ? 1 : 0),
    localparam int MAX_CYC   = (SAMPLE_CYC > LONG_CYC) ? SAMPLE_CYC : LONG_CYC,
    localparam int CNT_W     = $clog2(MAX_CYC + 1),
    localparam int IDX_W     = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             accept,
    output logic             in_trial,
    output logic             step_end,
    output logic             last_step,
    output logic [IDX_W-1:0] bit_idx,
    output logic             busy,
    output logic             sampling,
    output logic             done,
    output logic             irq
);

    seq_state_t       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             done_q, irq_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            idx_q   <= idx_n;
            irq_q   <= last_step;
            if (accept)
                done_q <= 1'b0;
            else if (last_step)
                done_q <= 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state_q;
        cnt_n     = cnt_q;
        idx_n     = idx_q;
        accept    = 1'b0;
        step_end  = 1'b0;
        last_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    state_n = ST_SAMPLE;
                    cnt_n   = CNT_W'(SAMPLE_CYC - 1);
                end
            end
            ST_SAMPLE: begin
                if (cnt_q == '0) begin
                    state_n = ST_TRIAL;
                    idx_n   = IDX_W'(RES_BITS - 1);
                    cnt_n   = CNT_W'(step_cycles(0, RES_BITS, SAMPLE_CYC, TOTAL_CYC) - 1);
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_TRIAL: begin
                if (cnt_q == '0) begin
                    step_end = 1'b1;
                    if (idx_q == '0) begin
                        last_step = 1'b1;
                        state_n   = ST_IDLE;
                    end else begin
                        idx_n = idx_q - 1'b1;
                        cnt_n = CNT_W'(step_cycles(RES_BITS - int'(idx_q), RES_BITS,
                                                   SAMPLE_CYC, TOTAL_CYC) - 1);
                    end
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign in_trial = (state_q == ST_TRIAL);
    assign sampling = (state_q == ST_SAMPLE);
    assign busy     = (state_q != ST_IDLE);
    assign bit_idx  = idx_q;
    assign done     = done_q;
    assign irq      = irq_q;

    assert_sample_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |-> (cnt_q < CNT_W'(SAMPLE_CYC)));
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    assert_idle_on_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && done));

endmodule

// File: rtl/sar_seq_reg.sv
`timescale 1ns/1ps
module sar_seq_reg #(
    parameter int RES_BITS = 5,
    parameter int CH_W     = 2,
    localparam int IDX_W   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [CH_W-1:0]     chan_in,
    input  logic                busy,
    input  logic                start,
    input  logic                in_trial,
    input  logic                step_end,
    input  logic                last_step,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                comp_in,
    output logic [CH_W-1:0]     mux_sel,
    output logic [RES_BITS-1:0] trial_code,
    output logic [RES_BITS-1:0] result
);

    logic [RES_BITS-1:0] work_q;
    logic [RES_BITS-1:0] result_q;
    logic [CH_W-1:0]     chan_q;
    logic [RES_BITS-1:0] probe;

    assign probe = RES_BITS'(1) << bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q   <= '0;
            result_q <= '0;
            chan_q   <= '0;
        end else begin
            if (accept) begin
                work_q <= '0;
                chan_q <= chan_in;
            end else if (step_end) begin
                work_q[bit_idx] <= comp_in;
            end
            if (last_step)
                result_q <= {work_q[RES_BITS-1:1], comp_in};
        end
    end

    assign trial_code = in_trial ? (work_q | probe) : '0;
    assign mux_sel    = chan_q;
    assign result     = result_q;

    assert_chan_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(mux_sel));
    assert_trial_probe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_trial |-> $onehot(trial_code ^ work_q));
    assert_result_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_step) |=> $stable(result));

endmodule

// File: rtl/sar_seq_fmt.sv
`timescale 1ns/1ps
module sar_seq_fmt #(
    parameter int RES_BITS = 5,
    parameter int BYTE_W   = 8,
    localparam int OUT_W   = RES_BITS - 1,
    localparam int PAD_W   = BYTE_W - RES_BITS
) (
    input  logic [RES_BITS-1:0] result,
    output logic [BYTE_W-1:0]   raw_byte,
    output logic [OUT_W-1:0]    corr
);

    logic [OUT_W:0] sum;

    generate
        if (PAD_W > 0) begin : g_pad
            assign raw_byte = {result, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign raw_byte = result[RES_BITS-1 -: BYTE_W];
        end
    endgenerate

    always_comb begin
        sum = {1'b0, result[RES_BITS-1:1]} + {{OUT_W{1'b0}}, result[0]};
        if (sum[OUT_W])
            corr = {OUT_W{1'b1}};
        else
            corr = sum[OUT_W-1:0];
    end

endmodule

// File: rtl/sar_adc_seq.sv
`timescale 1ns/1ps
module sar_adc_seq #(
    parameter int NUM_CH     = 4,
    parameter int RES_BITS   = 5,
    parameter int BYTE_W     = 8,
    parameter int SAMPLE_CYC = 12,
    parameter int TOTAL_CYC  = 160,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W     = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CH_W-1:0]     chan_i,
    input  logic                comp_i,
    output logic [CH_W-1:0]     mux_sel_o,
    output logic                sample_o,
    output logic [RES_BITS-1:0] trial_code_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                irq_o,
    output logic [BYTE_W-1:0]   raw_byte_o,
    output logic [RES_BITS-2:0] corr_o
);

    logic             accept, in_trial, step_end, last_step;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_BITS-1:0] result;

    sar_seq_ctrl #(
        .RES_BITS  (RES_BITS),
        .SAMPLE_CYC(SAMPLE_CYC),
        .TOTAL_CYC (TOTAL_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .accept   (accept),
        .in_trial (in_trial),
        .step_end (step_end),
        .last_step(last_step),
        .bit_idx  (bit_idx),
        .busy     (busy_o),
        .sampling (sample_o),
        .done     (done_o),
        .irq      (irq_o)
    );

    sar_seq_reg #(
        .RES_BITS(RES_BITS),
        .CH_W    (CH_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .chan_in   (chan_i),
        .busy      (busy_o),
        .start     (start_i),
        .in_trial  (in_trial),
        .step_end  (step_end),
        .last_step (last_step),
        .bit_idx   (bit_idx),
        .comp_in   (comp_i),
        .mux_sel   (mux_sel_o),
        .trial_code(trial_code_o),
        .result    (result)
    );

    sar_seq_fmt #(
        .RES_BITS(RES_BITS),
        .BYTE_W  (BYTE_W)
    ) u_fmt (
        .result  (result),
        .raw_byte(raw_byte_o),
        .corr    (corr_o)
    );

endmodule

// File: tb/tb_sar_adc_seq.sv
`timescale 1ns/1ps
module tb_sar_adc_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] chan_i = 2'd0;
    logic       comp_i;
    logic [1:0] mux_sel_o;
    logic       sample_o;
    logic [4:0] trial_code_o;
    logic       busy_o, done_o, irq_o;
    logic [7:0] raw_byte_o;
    logic [3:0] corr_o;

    logic [4:0] ain [4];

    int total_checks = 0;
    int fail_checks  = 0;
    bit finished     = 0;

    typedef struct {
        logic [7:0] raw;
        logic [3:0] corr;
    } exp_t;
    exp_t sb_q[$];
    logic [7:0] prev_raw = 8'h00;
    logic [3:0] prev_corr = 4'h0;

    always #4 clk = ~clk;

    // analog model: input at or above trial level
    assign comp_i = (ain[mux_sel_o] >= trial_code_o);

    sar_adc_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .comp_i(comp_i), .mux_sel_o(mux_sel_o), .sample_o(sample_o),
        .trial_code_o(trial_code_o), .busy_o(busy_o), .done_o(done_o),
        .irq_o(irq_o), .raw_byte_o(raw_byte_o), .corr_o(corr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total_checks++;
        if (!ok) begin
            fail_checks++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_corr(input int v);
        int t;
        t = (v / 2) + (v % 2);
        if (t > 15) t = 15;
        return 4'(t);
    endfunction

    // monitor: pops expected results on each completion pulse
    always @(negedge clk) begin
        if (rst_n && irq_o) begin
            if (sb_q.size() == 0) begin
                chk(0, "R9 unexpected irq", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(raw_byte_o == e.raw, "R4/R6 raw byte", raw_byte_o, e.raw);
                chk(corr_o == e.corr, "R7 corrected value", corr_o, e.corr);
            end
        end
    end

    // driver: one conversion, optional extra start while busy (R8)
    task automatic run_conv(input int ch, input int level, input int poke_at, input int poke_ch);
        int n, s, k, irq_cnt;
        int dur [5];
        logic [4:0] prev_code;
        bit probe_ok;
        exp_t e;
        ain[ch] = 5'(level);
        e.raw  = {5'(level), 3'b000};
        e.corr = exp_corr(level);
        sb_q.push_back(e);
        @(negedge clk);
        start_i = 1'b1;
        chan_i  = 2'(ch);
        @(negedge clk);
        start_i = 1'b0;
        chan_i  = 2'(3 - ch);
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        chk(done_o == 1'b0, "R9 done cleared by start", done_o, 0);
        chk(mux_sel_o == 2'(ch), "R2 channel latched", mux_sel_o, ch);
        n = 0; s = 0; k = -1; irq_cnt = 0; prev_code = 5'd0; probe_ok = 1;
        for (int i = 0; i < 5; i++) dur[i] = 0;
        while (busy_o && n < 400) begin
            n++;
            if (sample_o) s++;
            if (trial_code_o != 5'd0) begin
                if (trial_code_o != prev_code) begin
                    k++;
                    if (k < 5) begin
                        if ((trial_code_o & ((5'd2 << (4 - k)) - 5'd1)) != (5'd1 << (4 - k)))
                            probe_ok = 0;
                    end
                end
                if (k >= 0 && k < 5) dur[k]++;
                prev_code = trial_code_o;
            end
            if (irq_o) irq_cnt++;
            if (mux_sel_o != 2'(ch)) probe_ok = 0;
            if (n == 80) begin
                chk(raw_byte_o == prev_raw, "R10 raw held during conversion", raw_byte_o, prev_raw);
                chk(corr_o == prev_corr, "R10 corr held during conversion", corr_o, prev_corr);
            end
            if (poke_at > 0 && n == poke_at) begin
                start_i = 1'b1;
                chan_i  = 2'(poke_ch);
            end else if (poke_at > 0 && n == poke_at + 1) begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        chk(n == 160, "R3 busy length", n, 160);
        chk(s == 12, "R2 sample length", s, 12);
        chk(irq_o == 1'b1 && done_o == 1'b1, "R3 done/irq at busy fall", {irq_o, done_o}, 3);
        chk(irq_cnt == 0, "R9 no early irq", irq_cnt, 0);
        chk(probe_ok, "R5/R8 trial probe and channel hold", probe_ok, 1);
        for (int i = 0; i < 5; i++)
            chk(dur[i] == ((i < 3) ? 30 : 29), "R5 step length", dur[i], (i < 3) ? 30 : 29);
        @(negedge clk);
        chk(irq_o == 1'b0, "R9 irq single cycle", irq_o, 0);
        repeat (5) @(negedge clk);
        chk(done_o == 1'b1, "R9 done sticky", done_o, 1);
        chk(raw_byte_o[2:0] == 3'b000, "R6 low bits zero", raw_byte_o[2:0], 0);
        prev_raw  = e.raw;
        prev_corr = e.corr;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) ain[i] = 5'd0;
        repeat (3) @(negedge clk);
        chk(raw_byte_o == 8'h00 && corr_o == 4'h0, "R1 reset result", raw_byte_o, 0);
        chk(!done_o && !irq_o && !busy_o && !sample_o, "R1 reset flags",
            {done_o, irq_o, busy_o, sample_o}, 0);
        chk(trial_code_o == 5'd0, "R1 reset trial code", trial_code_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !done_o, "R1 idle after reset", {busy_o, done_o}, 0);
        run_conv(0, 0, 0, 0);
        run_conv(1, 31, 0, 0);   // R7 saturation
        run_conv(2, 1, 0, 0);
        run_conv(3, 29, 0, 0);   // R7 round to 15
        run_conv(0, 30, 0, 0);
        run_conv(1, 16, 50, 3);  // R8 start while busy
        run_conv(2, 7, 0, 0);
        run_conv(3, 15, 0, 0);
        run_conv(1, 20, 150, 0); // R8 late extra start
        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R9 all completions seen", sb_q.size(), 0);
        chk(!busy_o, "R8 no restart after ignored start", busy_o, 0);
        finished = 1;
        $display("%0d/%0d checks passed", total_checks - fail_checks, total_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total_checks++;
            fail_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total_checks - fail_checks, total_checks);
            $finish;
        end
    end

endmodule